// File: doc/BRIEF.md
# UART Transmitter with Flow Control

This block turns queued bytes into asynchronous serial frames on a single output line. Bytes enter through a small internal queue. A framing state machine pops them one at a time and sends each one as a low start bit, eight data bits with the least significant bit first, and a high stop bit. A programmable divisor sets the bit time, counted in system clock cycles. An optional idle gap, counted in whole bit times, can be placed after each stop bit. The line rests high whenever there is nothing to send.

Two further controls shape when a frame may begin. When clear-to-send gating is enabled, a new frame starts only while the active-low `cts_n` input is asserted. The input is sampled only when a frame is about to begin, so a frame that has started always finishes. A break request holds the line low for a programmable number of bit times, with a floor of ten, and then returns it to the high level for one bit. Writing the divisor empties the queue, drops any pending break and returns the engine to its resting state.

The state machine has six states:
- IDLE: the line is high. The machine launches from here.
- START: the low start bit. It moves to DATA on a bit tick.
- DATA: eight bit times. It moves to STOP after the eighth bit.
- STOP: one high bit time. It either reaches a launch point or moves to GAP.
- GAP: the programmed number of high bit times, ending at a launch point.
- BREAK: a low hold. It moves to STOP when its count runs out.

At every launch point, reached from IDLE, from the end of STOP with a zero gap, or from the end of GAP, the machine makes one choice. A pending break takes it to BREAK. Otherwise, a queued byte that CTS gating allows takes it to START. If neither applies, it goes to IDLE. A divisor write sends any state to IDLE.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, `txd` is 1, `tx_busy` is 0, `fifo_full` is 0, and CTS gating is disabled.
- R2: A frame is one 0 start bit, then eight data bits with bit 0 first, then one 1 stop bit. Each bit lasts max(divisor, 1) clock cycles, so a divisor of 0 behaves as 1.
- R3: While no byte is queued and no break is pending, `txd` stays 1 and `tx_busy` stays 0.
- R4: With a gap of 0 and more bytes queued, the next start bit begins in the cycle right after the previous stop bit ends. Start bits are therefore exactly 10 bit times apart.
- R5: With a gap of N, the line stays high for N extra bit times after each stop bit. Start bits are then (10+N) bit times apart.
- R6: While gating is disabled, frames are sent whatever the level of `cts_n`.
- R7: Writing 1 through the gate-enable port enables gating. While it is enabled, no frame starts while `cts_n` is 1. A queued byte starts once `cts_n` has been 0.
- R8: A frame that has started runs to its stop bit even if `cts_n` rises during the frame.
- R9: A break request drives `txd` low for max(length, 10) bit times, followed by at least one high bit time. A request made during a frame waits until that frame's stop bit has ended.
- R10: A divisor write aborts any frame in progress and discards the queued bytes, and `txd` returns to 1.
- R11: The queue holds DEPTH bytes and raises `fifo_full` when it holds DEPTH. A write made while it is full is dropped. Bytes are sent in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write a byte into the queue |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds DEPTH bytes |
| div_wr | input | 1 | Load the divisor; also flushes the block |
| div_wdata | input | DIV_W | Bit time in clock cycles |
| cts_en_wr | input | 1 | Load the gating enable |
| cts_en_wdata | input | 1 | 1 enables CTS gating |
| gap_wr | input | 1 | Load the inter-frame gap |
| gap_wdata | input | GAP_W | Gap in bit times |
| brk_wr | input | 1 | Request a break |
| brk_len | input | BRK_W | Break length in bit times (floor 10) |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output |
| tx_busy | output | 1 | Engine is outside IDLE |

## Verification
The bench builds the block with DEPTH=4, DIV_W=8, GAP_W=4, BRK_W=6 and a reset divisor of 4. These values keep every frame to 40 cycles, so spacing, gap and break lengths can be checked to the exact cycle. A four-entry queue can be filled while gating holds the line, which brings the full flag and the dropped overflow write within reach. A 6-bit break length can express values both below and above the ten-bit floor. A divisor of 7 exercises an odd bit time, and a divisor of 0 exercises the one-cycle floor.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam int DATA_BITS      = 8;
    localparam int BREAK_MIN_BITS = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_GAP,
        ST_BREAK
    } tx_state_e;

endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/stx_fifo.sv
module stx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rptr];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wrap_inc(wptr);
            if (do_pop)  rptr <= wrap_inc(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/stx_baud.sv
module stx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             last;

    assign last = (cnt >= div - DIV_W'(1));
    assign tick = last && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/stx_engine.sv
module stx_engine
    import serial_tx_pkg::*;
#(
    parameter int GAP_W = 8,
    parameter int BRK_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 abort,
    input  logic                 tick,
    input  logic                 gate_en,
    input  logic                 cts_n_s,
    input  logic                 q_empty,
    input  logic [DATA_BITS-1:0] q_head,
    input  logic [GAP_W-1:0]     gap_bits,
    input  logic                 brk_req,
    input  logic [BRK_W-1:0]     brk_len,
    output logic                 q_pop,
    output logic                 baud_restart,
    output logic                 txd,
    output logic                 busy,
    output tx_state_e            state_o
);

    localparam int BLW      = (BRK_W > 4) ? BRK_W : 4;
    localparam int IDXW     = $clog2(DATA_BITS);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DATA_BITS - 1);

    tx_state_e            state, state_n;
    logic [DATA_BITS-1:0] shreg;
    logic [IDXW-1:0]      bit_idx;
    logic [GAP_W-1:0]     gap_left;
    logic [BLW-1:0]       brk_left;
    logic                 brk_pend;
    logic [BRK_W-1:0]     brk_len_q;

    logic cts_ok, want_brk, want_data, boundary;
    logic launch_brk, launch_data;

    assign cts_ok    = !gate_en || !cts_n_s;
    assign want_brk  = brk_pend;
    assign want_data = !q_empty && cts_ok;

    // next-state logic
    always_comb begin
        boundary = 1'b0;
        state_n  = state;
        unique case (state)
            ST_IDLE:  boundary = 1'b1;
            ST_START: if (tick) state_n = ST_DATA;
            ST_DATA:  if (tick && bit_idx == LAST_IDX) state_n = ST_STOP;
            ST_STOP: begin
                if (tick) begin
                    if (gap_bits == '0) boundary = 1'b1;
                    else                state_n  = ST_GAP;
                end
            end
            ST_GAP:   if (tick && gap_left == GAP_W'(1)) boundary = 1'b1;
            ST_BREAK: if (tick && brk_left == BLW'(1)) state_n = ST_STOP;
            default:  state_n = ST_IDLE;
        endcase
        if (boundary) begin
            if (want_brk)       state_n = ST_BREAK;
            else if (want_data) state_n = ST_START;
            else                state_n = ST_IDLE;
        end
    end

    assign launch_brk   = boundary && want_brk;
    assign launch_data  = boundary && !want_brk && want_data;
    assign q_pop        = launch_data;
    assign baud_restart = (state == ST_IDLE) && (launch_brk || launch_data);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (abort) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_idx   <= '0;
            gap_left  <= '0;
            brk_left  <= '0;
            brk_pend  <= 1'b0;
            brk_len_q <= '0;
        end else begin
            if (launch_data) begin
                shreg   <= q_head;
                bit_idx <= '0;
            end else if (state == ST_DATA && tick) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + IDXW'(1);
            end

            if (state == ST_STOP && tick) begin
                gap_left <= gap_bits;
            end else if (state == ST_GAP && tick) begin
                gap_left <= gap_left - GAP_W'(1);
            end

            if (launch_brk) begin
                brk_left <= (BLW'(brk_len_q) < BLW'(BREAK_MIN_BITS))
                            ? BLW'(BREAK_MIN_BITS) : BLW'(brk_len_q);
            end else if (state == ST_BREAK && tick) begin
                brk_left <= brk_left - BLW'(1);
            end

            if (abort) begin
                brk_pend <= 1'b0;
            end else if (brk_req) begin
                brk_pend  <= 1'b1;
                brk_len_q <= brk_len;
            end else if (launch_brk) begin
                brk_pend <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_START, ST_BREAK: txd = 1'b0;
            ST_DATA:            txd = shreg[0];
            default:            txd = 1'b1;
        endcase
        busy    = (state != ST_IDLE);
        state_o = state;
    end

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import serial_tx_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DIV_W    = 16,
    parameter int GAP_W    = 8,
    parameter int BRK_W    = 8,
    parameter int DIV_INIT = 16,
    parameter int GAP_INIT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    output logic                 fifo_full,
    input  logic                 div_wr,
    input  logic [DIV_W-1:0]     div_wdata,
    input  logic                 cts_en_wr,
    input  logic                 cts_en_wdata,
    input  logic                 gap_wr,
    input  logic [GAP_W-1:0]     gap_wdata,
    input  logic                 brk_wr,
    input  logic [BRK_W-1:0]     brk_len,
    input  logic                 cts_n,
    output logic                 txd,
    output logic                 tx_busy
);

    logic [DIV_W-1:0]     div_q, div_eff;
    logic                 gate_q;
    logic [GAP_W-1:0]     gap_q;
    logic                 cts_n_s;
    logic                 eng_pop, fq_empty, baud_restart, baud_tick;
    logic [DATA_BITS-1:0] fq_head;
    tx_state_e            eng_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= DIV_W'(DIV_INIT);
            gate_q <= 1'b0;
            gap_q  <= GAP_W'(GAP_INIT);
        end else begin
            if (div_wr)    div_q  <= div_wdata;
            if (cts_en_wr) gate_q <= cts_en_wdata;
            if (gap_wr)    gap_q  <= gap_wdata;
        end
    end

    assign div_eff = (div_q == '0) ? DIV_W'(1) : div_q;

    stx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_n),
        .q     (cts_n_s)
    );

    stx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_BITS)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (div_wr),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (eng_pop),
        .head      (fq_head),
        .empty     (fq_empty),
        .full      (fifo_full)
    );

    stx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div_eff),
        .restart (baud_restart),
        .tick    (baud_tick)
    );

    stx_engine #(.GAP_W(GAP_W), .BRK_W(BRK_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort        (div_wr),
        .tick         (baud_tick),
        .gate_en      (gate_q),
        .cts_n_s      (cts_n_s),
        .q_empty      (fq_empty),
        .q_head       (fq_head),
        .gap_bits     (gap_q),
        .brk_req      (brk_wr),
        .brk_len      (brk_len),
        .q_pop        (eng_pop),
        .baud_restart (baud_restart),
        .txd          (txd),
        .busy         (tx_busy),
        .state_o      (eng_state)
    );

endmodule

// File: rtl/stx_chk.sv
module stx_chk
    import serial_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             abort,
    input logic             txd,
    input logic             busy,
    input logic             fifo_pop,
    input logic             fifo_empty,
    input tx_state_e        state,
    input logic             gate_en,
    input logic             cts_s,
    input logic [DIV_W-1:0] div_eff
);

    logic [31:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   low_run <= '0;
        else if (!txd) low_run <= low_run + 32'd1;
        else          low_run <= '0;
    end

    // R3
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R11
    no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R2
    pop_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !abort) |=> (state == ST_START));

    // R7
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START)
            |-> (!$past(gate_en) || !$past(cts_s)));

    // R9
    break_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && $past(state) == ST_BREAK)
            |-> (low_run >= 32'(BREAK_MIN_BITS) * 32'(div_eff)));

endmodule

bind uart_tx_flow stx_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (div_wr),
    .txd        (txd),
    .busy       (tx_busy),
    .fifo_pop   (eng_pop),
    .fifo_empty (fq_empty),
    .state      (eng_state),
    .gate_en    (gate_q),
    .cts_s      (cts_n_s),
    .div_eff    (div_eff)
);

// File: tb/uart_tx_flow_test.sv
module uart_tx_flow_test;

    localparam int DEPTH = 4;
    localparam int DIV_W = 8;
    localparam int GAP_W = 4;
    localparam int BRK_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             fifo_full;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_wdata = '0;
    logic             cts_en_wr = 1'b0;
    logic             cts_en_wdata = 1'b0;
    logic             gap_wr = 1'b0;
    logic [GAP_W-1:0] gap_wdata = '0;
    logic             brk_wr = 1'b0;
    logic [BRK_W-1:0] brk_len = '0;
    logic             cts_n = 1'b1;
    logic             txd;
    logic             tx_busy;

    uart_tx_flow #(
        .DEPTH(DEPTH), .DIV_W(DIV_W), .GAP_W(GAP_W), .BRK_W(BRK_W),
        .DIV_INIT(4), .GAP_INIT(0)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .div_wr(div_wr), .div_wdata(div_wdata),
        .cts_en_wr(cts_en_wr), .cts_en_wdata(cts_en_wdata),
        .gap_wr(gap_wr), .gap_wdata(gap_wdata), .brk_wr(brk_wr),
        .brk_len(brk_len), .cts_n(cts_n), .txd(txd), .tx_busy(tx_busy)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // frame monitor
    int         mon_div = 4;
    int         n_frames = 0;
    logic [7:0] f_data [64];
    int         f_t    [64];
    bit         f_ok   [64];

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                int d;
                int t;
                logic [7:0] b;
                logic s0, sp;
                t = cyc;
                d = mon_div;
                repeat (d / 2) @(negedge clk);
                s0 = txd;
                for (int i = 0; i < 8; i++) begin
                    repeat (d) @(negedge clk);
                    b[i] = txd;
                end
                repeat (d) @(negedge clk);
                sp = txd;
                if (n_frames < 64) begin
                    f_data[n_frames] = b;
                    f_t[n_frames]    = t;
                    f_ok[n_frames]   = (s0 == 1'b0) && (sp == 1'b1);
                end
                n_frames++;
                if (sp !== 1'b1) begin
                    while (txd !== 1'b1) @(negedge clk);
                end
            end
        end
    end

    // low-run monitor
    int run = 0;
    int max_low = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            run = 0;
        end else if (txd === 1'b0) begin
            run++;
        end else if (run > 0) begin
            if (run > max_low) max_low = run;
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_div(input int v);
        @(negedge clk);
        div_wr = 1'b1; div_wdata = DIV_W'(v);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic write_gate(input logic v);
        @(negedge clk);
        cts_en_wr = 1'b1; cts_en_wdata = v;
        @(negedge clk);
        cts_en_wr = 1'b0;
    endtask

    task automatic write_gap(input int v);
        @(negedge clk);
        gap_wr = 1'b1; gap_wdata = GAP_W'(v);
        @(negedge clk);
        gap_wr = 1'b0;
    endtask

    task automatic req_break(input int len);
        @(negedge clk);
        brk_wr = 1'b1; brk_len = BRK_W'(len);
        @(negedge clk);
        brk_wr = 1'b0;
    endtask

    task automatic wait_frames(input int n, input string req);
        int k;
        k = 0;
        while (n_frames < n && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(n_frames >= n, req, n_frames, n);
    endtask

    task automatic wait_idle();
        int k;
        k = 0;
        repeat (4) @(negedge clk);
        while (tx_busy && k < 5000) begin
            @(negedge clk);
            k++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req);
        bit low_seen;
        low_seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (txd !== 1'b1) low_seen = 1'b1;
        end
        chk(!low_seen, req, int'(low_seen), 0);
    endtask

    task automatic t_reset();
        chk(txd === 1'b1, "R1 txd", int'(txd), 1);
        chk(tx_busy === 1'b0, "R1 busy", int'(tx_busy), 0);
        chk(fifo_full === 1'b0, "R1 full", int'(fifo_full), 0);
        quiet(50, "R3 idle line");
    endtask

    task automatic t_basic();
        // R6: gating is off after reset, cts_n held high
        n_frames = 0;
        push(8'hA5); push(8'h3C); push(8'h81);
        wait_frames(3, "R6 frames sent with cts_n high");
        chk(f_data[0] == 8'hA5 && f_ok[0], "R2 frame 0", int'(f_data[0]), 'hA5);
        chk(f_data[1] == 8'h3C && f_ok[1], "R2 frame 1", int'(f_data[1]), 'h3C);
        chk(f_data[2] == 8'h81 && f_ok[2], "R2 frame 2", int'(f_data[2]), 'h81);
        chk(f_t[1] - f_t[0] == 40, "R4 spacing 0-1", f_t[1] - f_t[0], 40);
        chk(f_t[2] - f_t[1] == 40, "R4 spacing 1-2", f_t[2] - f_t[1], 40);
        wait_idle();
    endtask

    task automatic t_gap();
        write_gap(3);
        n_frames = 0;
        push(8'h5E); push(8'hC1);
        wait_frames(2, "R5 gap frames");
        chk(f_data[1] == 8'hC1 && f_ok[1], "R5 data", int'(f_data[1]), 'hC1);
        chk(f_t[1] - f_t[0] == 52, "R5 gap spacing", f_t[1] - f_t[0], 52);
        wait_idle();
        write_gap(0);
    endtask

    task automatic t_divisor();
        write_div(7);
        mon_div = 7;
        n_frames = 0;
        push(8'h5A); push(8'hC3);
        wait_frames(2, "R2 div7 frames");
        chk(f_data[0] == 8'h5A && f_ok[0], "R2 div7 data", int'(f_data[0]), 'h5A);
        chk(f_t[1] - f_t[0] == 70, "R2 div7 spacing", f_t[1] - f_t[0], 70);
        wait_idle();
        write_div(0);
        mon_div = 1;
        n_frames = 0;
        push(8'h96); push(8'h69);
        wait_frames(2, "R2 div0 frames");
        chk(f_data[0] == 8'h96 && f_data[1] == 8'h69, "R2 div0 data",
            int'(f_data[1]), 'h69);
        chk(f_t[1] - f_t[0] == 10, "R2 div0 spacing", f_t[1] - f_t[0], 10);
        wait_idle();
        write_div(4);
        mon_div = 4;
    endtask

    task automatic t_gate();
        write_gate(1'b1);
        cts_n = 1'b1;
        n_frames = 0;
        push(8'h42);
        quiet(100, "R7 blocked while cts_n high");
        chk(n_frames == 0, "R7 no frame", n_frames, 0);
        cts_n = 1'b0;
        wait_frames(1, "R7 released");
        chk(f_data[0] == 8'h42 && f_ok[0], "R7 data", int'(f_data[0]), 'h42);
        wait_idle();
        n_frames = 0;
        push(8'h99); push(8'h18);
        while (txd !== 1'b0) @(negedge clk);
        cts_n = 1'b1;
        wait_frames(1, "R8 frame completes");
        chk(f_data[0] == 8'h99 && f_ok[0], "R8 data intact", int'(f_data[0]), 'h99);
        quiet(100, "R7 second byte held");
        chk(n_frames == 1, "R7 held count", n_frames, 1);
        cts_n = 1'b0;
        wait_frames(2, "R7 second released");
        chk(f_data[1] == 8'h18, "R7 second data", int'(f_data[1]), 'h18);
        wait_idle();
        write_gate(1'b0);
    endtask

    task automatic t_break();
        max_low = 0;
        req_break(3);
        wait_idle();
        chk(max_low == 40, "R9 floor of 10 bits", max_low, 40);
        max_low = 0;
        req_break(13);
        wait_idle();
        chk(max_low == 52, "R9 length 13", max_low, 52);
        max_low = 0;
        n_frames = 0;
        push(8'h0F);
        req_break(0);
        wait_idle();
        chk(f_data[0] == 8'h0F && f_ok[0], "R9 frame before break",
            int'(f_data[0]), 'h0F);
        chk(max_low == 40, "R9 break after frame", max_low, 40);
        n_frames = 0;
        push(8'h77);
        wait_frames(1, "R9 frame after break");
        chk(f_data[0] == 8'h77 && f_ok[0], "R9 data after break",
            int'(f_data[0]), 'h77);
        wait_idle();
    endtask

    task automatic t_full();
        write_gate(1'b1);
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        n_frames = 0;
        push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        chk(fifo_full === 1'b1, "R11 full at depth", int'(fifo_full), 1);
        push(8'hEE);
        cts_n = 1'b0;
        wait_frames(4, "R11 drain");
        quiet(150, "R11 overflow dropped");
        chk(n_frames == 4, "R11 frame count", n_frames, 4);
        for (int i = 0; i < 4; i++) begin
            chk(f_data[i] == 8'(i + 1), "R11 order", int'(f_data[i]), i + 1);
        end
        wait_idle();
        write_gate(1'b0);
    endtask

    task automatic t_flush();
        n_frames = 0;
        push(8'h11); push(8'h22); push(8'h33);
        while (txd !== 1'b0) @(negedge clk);
        repeat (8) @(negedge clk);
        write_div(4);
        chk(tx_busy === 1'b0, "R10 aborted", int'(tx_busy), 0);
        chk(txd === 1'b1, "R10 line high", int'(txd), 1);
        chk(fifo_full === 1'b0, "R10 queue empty", int'(fifo_full), 0);
        quiet(200, "R10 queued bytes discarded");
        n_frames = 0;
        push(8'h44);
        wait_frames(1, "R10 sends after flush");
        chk(f_data[0] == 8'h44 && f_ok[0], "R10 data", int'(f_data[0]), 'h44);
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_gap();
        t_divisor();
        t_gate();
        t_break();
        t_full();
        t_flush();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule